// File: doc/BRIEF.md
# Dual-Read Bit-Slice Register File

This block is a small register file of eight locations, each `WIDTH` bits wide, with one write port and two read ports that work independently. Every rising clock edge stores the write data into the location picked by a 3-bit write address. There is no write enable. Each read port has its own 3-bit address. Each read port ends in a level-sensitive output latch. The latch is open while the clock is high and closed while the clock is low, so the read word stays steady for the whole low phase, even if the read address moves.

A single active-low input forces both output latches open at any clock level. This gives a purely combinational read path. With `WIDTH` set to 1 the block is one bit-slice. Larger widths behave like that many slices placed side by side that share the clock and all address lines, and they deliver two words per cycle. The storage has no reset, so a location holds an undefined value until it has been written once.

Top module: `twin_tap_regfile`

## Requirements
- R1: The storage holds eight locations. Location k (k = 0..7) is addressed by the binary value k on a 3-bit address, and each location can be written and read back on its own.
- R2: On every rising clock edge the value on `wr_data` is stored into location `wr_addr`. No enable exists, so each edge performs a write.
- R3: Read port B and read port C each select their location from their own address. They may select different locations or the same location, in the same cycle as a write.
- R4: While `clk` is high, `rdb_q` equals the content of location `rdb_addr` and `rdc_q` equals the content of location `rdc_addr`.
- R5: While `clk` is low and `open_n` is high, each read output keeps the value it had at the falling edge, whatever its read address does.
- R6: When the write address equals a read address, the read output shows the newly written data during the high phase that follows that rising edge. It never shows a stale or mixed value.
- R7: All `WIDTH` bits of a location are written and read together under the shared addresses. Each bit behaves as an independent slice.
- R8: While `open_n` is low, both read outputs follow the content of their addressed locations at both clock levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge writes, high level opens output latches |
| open_n | input | 1 | Active-low force-open for both output latches |
| wr_addr | input | 3 | Write location select |
| wr_data | input | WIDTH | Data stored at each rising edge |
| rdb_addr | input | 3 | Read port B location select |
| rdc_addr | input | 3 | Read port C location select |
| rdb_q | output | WIDTH | Read port B latched output |
| rdc_q | output | WIDTH | Read port C latched output |

## Verification
The write to a location and the read of that same location coincide whenever a read address equals the write address at a rising edge. The bench forces this case with directed cycles on both ports, and random addresses produce it again many times. It is judged by checking, in the middle of the following high phase, that the output carries the new data. The bench also checks, in the low phase after the read address has moved, that the output still holds that new data unless the force-open input is low.

// File: rtl/twin_tap_pkg.sv
package twin_tap_pkg;
  localparam int ADDR_W = 3;
  localparam int DEPTH  = 1 << ADDR_W;
  typedef logic [ADDR_W-1:0] loc_t;
endpackage

// File: rtl/twin_tap_wdec.sv
module twin_tap_wdec
  import twin_tap_pkg::*;
(
  input  loc_t             addr,
  output logic [DEPTH-1:0] row_sel
);
  always_comb begin
    row_sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (addr == loc_t'(i)) row_sel[i] = 1'b1;
    end
  end
endmodule

// File: rtl/twin_tap_store.sv
module twin_tap_store
  import twin_tap_pkg::*;
#(
  parameter int WIDTH = 1
) (
  input  logic                   clk,
  input  logic [DEPTH-1:0]       row_sel,
  input  logic [WIDTH-1:0]       wr_data,
  output logic [DEPTH*WIDTH-1:0] cells
);
  // Master cells: no reset, every edge writes exactly one row.
  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic [WIDTH-1:0] row_q;
    always_ff @(posedge clk) begin
      if (row_sel[r]) row_q <= wr_data;
    end
    assign cells[r*WIDTH +: WIDTH] = row_q;
  end
endmodule

// File: rtl/twin_tap_port.sv
module twin_tap_port
  import twin_tap_pkg::*;
#(
  parameter int WIDTH = 1
) (
  input  logic                   gate,
  input  loc_t                   addr,
  input  logic [DEPTH*WIDTH-1:0] cells,
  output logic [WIDTH-1:0]       q
);
  logic [WIDTH-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (addr == loc_t'(i)) pick = cells[i*WIDTH +: WIDTH];
    end
  end

  // Slave latch: transparent while gate is high, holds otherwise.
  always_latch begin
    if (gate) q = pick;
  end
endmodule

// File: rtl/twin_tap_regfile.sv
module twin_tap_regfile
  import twin_tap_pkg::*;
#(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             open_n,
  input  logic [2:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [2:0]       rdb_addr,
  input  logic [2:0]       rdc_addr,
  output logic [WIDTH-1:0] rdb_q,
  output logic [WIDTH-1:0] rdc_q
);
  logic [DEPTH-1:0]       row_sel;
  logic [DEPTH*WIDTH-1:0] cells;
  logic                   gate;

  assign gate = clk | ~open_n;

  twin_tap_wdec u_wdec (
    .addr    (wr_addr),
    .row_sel (row_sel)
  );

  twin_tap_store #(.WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .row_sel (row_sel),
    .wr_data (wr_data),
    .cells   (cells)
  );

  twin_tap_port #(.WIDTH(WIDTH)) u_port_b (
    .gate  (gate),
    .addr  (rdb_addr),
    .cells (cells),
    .q     (rdb_q)
  );

  twin_tap_port #(.WIDTH(WIDTH)) u_port_c (
    .gate  (gate),
    .addr  (rdc_addr),
    .cells (cells),
    .q     (rdc_q)
  );
endmodule

// File: rtl/twin_tap_regfile_chk.sv
module twin_tap_regfile_chk
  import twin_tap_pkg::*;
#(
  parameter int WIDTH = 1
) (
  input logic                   clk,
  input logic                   open_n,
  input logic [2:0]             wr_addr,
  input logic [WIDTH-1:0]       wr_data,
  input logic [2:0]             rdb_addr,
  input logic [2:0]             rdc_addr,
  input logic [WIDTH-1:0]       rdb_q,
  input logic [WIDTH-1:0]       rdc_q,
  input logic [DEPTH*WIDTH-1:0] cells
);
  function automatic logic [WIDTH-1:0] word_at(input logic [DEPTH*WIDTH-1:0] c,
                                               input logic [2:0] a);
    logic [WIDTH-1:0] w;
    w = '0;
    for (int i = 0; i < DEPTH; i++) if (a == 3'(i)) w = c[i*WIDTH +: WIDTH];
    return w;
  endfunction

  logic       warm = 1'b0;
  logic       kept = 1'b0;
  logic [WIDTH-1:0] cap_b = '0;
  logic [WIDTH-1:0] cap_c = '0;

  always_ff @(posedge clk) warm <= 1'b1;

  // Capture outputs at the falling edge; a force-open during the low phase voids the capture.
  always_ff @(negedge clk or negedge open_n) begin
    if (!open_n) begin
      kept <= 1'b0;
    end else begin
      kept  <= 1'b1;
      cap_b <= rdb_q;
      cap_c <= rdc_q;
    end
  end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!warm)
    1'b1 |=> word_at(cells, $past(wr_addr)) == $past(wr_data));

  assert_high_follow_b_R4: assert property (@(negedge clk) disable iff (!warm)
    rdb_q == word_at(cells, rdb_addr));

  assert_high_follow_c_R3: assert property (@(negedge clk) disable iff (!warm)
    rdc_q == word_at(cells, rdc_addr));

  assert_low_hold_R5: assert property (@(posedge clk) disable iff (!warm)
    (kept && open_n) |-> (rdb_q == cap_b && rdc_q == cap_c));

  assert_force_open_R8: assert property (@(posedge clk) disable iff (!warm)
    !open_n |-> (rdb_q == word_at(cells, rdb_addr) && rdc_q == word_at(cells, rdc_addr)));
endmodule

bind twin_tap_regfile twin_tap_regfile_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .open_n   (open_n),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rdb_addr (rdb_addr),
  .rdc_addr (rdc_addr),
  .rdb_q    (rdb_q),
  .rdc_q    (rdc_q),
  .cells    (cells)
);

// File: tb/tb_twin_tap_regfile.sv
`timescale 1ns/100ps
module tb_twin_tap_regfile;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         open_n = 1'b1;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [2:0]   rdb_addr = '0;
  logic [2:0]   rdc_addr = '0;
  logic [W-1:0] rdb_q, rdc_q;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] model [8];

  always #2 clk = ~clk;  // 250 MHz

  twin_tap_regfile #(.WIDTH(W)) dut (
    .clk(clk), .open_n(open_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .rdb_addr(rdb_addr), .rdc_addr(rdc_addr), .rdb_q(rdb_q), .rdc_q(rdc_q)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle, entered just after a falling edge.
  task automatic cyc(input logic [2:0] wa, input logic [W-1:0] wd,
                     input logic [2:0] ba, input logic [2:0] ca, input logic on,
                     input logic [2:0] ba2, input logic [2:0] ca2,
                     input string hi_tag, input string lo_tag);
    logic [W-1:0] held_b, held_c;
    #0.2;
    wr_addr = wa; wr_data = wd; rdb_addr = ba; rdc_addr = ca; open_n = on;
    @(posedge clk);
    model[wa] = wd;
    #1;
    held_b = model[ba];
    held_c = model[ca];
    check({hi_tag, " port B high"}, rdb_q, held_b);
    check({hi_tag, " port C high"}, rdc_q, held_c);
    @(negedge clk);
    #0.3;
    rdb_addr = ba2; rdc_addr = ca2;
    #0.7;
    check({lo_tag, " port B low"}, rdb_q, on ? held_b : model[ba2]);
    check({lo_tag, " port C low"}, rdc_q, on ? held_c : model[ca2]);
  endtask

  initial begin : watchdog
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    // R1 / R2: fill every location with a distinct pattern, one per edge.
    for (int k = 0; k < 8; k++)
      cyc(3'(k), W'(8'h11 * (k + 1)), 3'(k), 3'(7 - k), 1'b1, 3'(k), 3'(7 - k), "R2", "R5");
    // R1: read every location back on port B while writing a don't-care row.
    for (int k = 0; k < 8; k++)
      cyc(3'(0), 8'h11, 3'(k), 3'(k), 1'b1, 3'(k), 3'(k), "R1", "R1");
    // R7: complementary bit patterns exercise all slices.
    cyc(3'd3, 8'hA5, 3'd3, 3'd4, 1'b1, 3'd3, 3'd4, "R7", "R7");
    cyc(3'd4, 8'h5A, 3'd3, 3'd4, 1'b1, 3'd3, 3'd4, "R7", "R7");
    // R3: both ports on the same location, then on different ones.
    cyc(3'd6, 8'h3C, 3'd2, 3'd2, 1'b1, 3'd2, 3'd2, "R3", "R3");
    cyc(3'd6, 8'hC3, 3'd1, 3'd5, 1'b1, 3'd1, 3'd5, "R3", "R3");
    // R6: read-during-write of the same location on both ports.
    cyc(3'd5, 8'hE7, 3'd5, 3'd5, 1'b1, 3'd5, 3'd5, "R6", "R6");
    cyc(3'd2, 8'h81, 3'd2, 3'd0, 1'b1, 3'd2, 3'd0, "R6", "R6");
    // R5: addresses move in the low phase; outputs must hold.
    cyc(3'd0, 8'h0F, 3'd0, 3'd1, 1'b1, 3'd7, 3'd6, "R4", "R5");
    cyc(3'd7, 8'hF0, 3'd7, 3'd6, 1'b1, 3'd3, 3'd4, "R4", "R5");
    // R8: force-open makes the low phase follow the new address.
    cyc(3'd1, 8'h99, 3'd1, 3'd2, 1'b0, 3'd5, 3'd6, "R8", "R8");
    cyc(3'd1, 8'h66, 3'd4, 3'd1, 1'b0, 3'd1, 3'd4, "R8", "R8");
    // Random mix (R4, R5, R8).
    for (int n = 0; n < 400; n++) begin
      logic on_r;
      on_r = ($urandom % 4) != 0;
      cyc(3'($urandom), W'($urandom), 3'($urandom), 3'($urandom), on_r,
          3'($urandom), 3'($urandom), "R4", on_r ? "R5" : "R8");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule